// File: doc/BRIEF.md
# Nibble ALU With Skip Logic

This block is the 4-bit arithmetic and test stage of a small microcontroller core. Each cycle in which a strobe is raised, it takes one 8-bit opcode together with the current accumulator, a RAM nibble and the carry flag. One clock later it returns the updated accumulator and carry. It also returns a flag that tells the sequencer to skip the next instruction.

The block executes the following instructions:
- an immediate add;
- two register adds that share one carry chain and differ only in whether a carry-out requests a skip;
- an equality test against an immediate;
- a single-bit test of the accumulator;
- a test of the carry flag.

Opcodes that belong to other units (jumps, loads and the rest) are recognised and marked as pass-through. A small set of reserved codes is marked illegal. Neither kind touches the accumulator or the carry.

The sequencer feeds its pending skip back on a skip input. When that input is high, the opcode presented with it is swallowed: state is returned unchanged and the skip request is dropped.

Top module: `nibble_alu_skip`

## Requirements
- R1: Opcodes 0x00..0x0F give acc_o = (acc_i + opcode[3:0]) mod 16, with skip_o = 1 exactly when that sum exceeds 15. The carry is returned unchanged.
- R2: Opcodes 0x10..0x1F give skip_o = 1 exactly when acc_i equals opcode[3:0]. The accumulator and carry are returned unchanged.
- R3: Opcodes 0x64..0x67 give skip_o = acc_i[opcode[1:0]]. The accumulator and carry are returned unchanged.
- R4: Opcode 0x73 gives acc_o = (acc_i + ram_i + carry_i) mod 16. carry_o is the carry-out of that sum, and skip_o equals that carry-out.
- R5: Opcode 0x72 performs the same sum and carry update as R4, but skip_o is always 0.
- R6: Opcode 0x54 gives skip_o = carry_i. The accumulator and carry are returned unchanged.
- R7: Any other legal opcode is treated as pass-through, including 0x30..0x3F, 0x80..0xFF and 0x40. It gives pass_o = 1, illegal_o = 0 and skip_o = 0, with the accumulator and carry unchanged.
- R8: Opcodes 0x4E, 0x4F and 0x58..0x5B give illegal_o = 1, pass_o = 0 and skip_o = 0, with the accumulator and carry unchanged.
- R9: When skip_i is high together with valid_i, the opcode is suppressed. acc_o and carry_o equal the inputs, and skip_o, illegal_o and pass_o are all 0.
- R10: valid_o is high exactly one cycle after each cycle with valid_i high. The outputs hold their values while valid_i is low. After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operands and opcode are presented this cycle |
| skip_i | input | 1 | Pending skip: suppress this opcode |
| opcode_i | input | 8 | Instruction byte |
| acc_i | input | 4 | Current accumulator |
| ram_i | input | 4 | Addressed RAM nibble |
| carry_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| acc_o | output | 4 | New accumulator |
| carry_o | output | 1 | New carry flag |
| skip_o | output | 1 | Skip the next instruction |
| illegal_o | output | 1 | Opcode is reserved |
| pass_o | output | 1 | Opcode is legal but executed elsewhere |

## Verification
Suppression by skip_i and an instruction's own carry-driven skip can arise in the same cycle. The bench provokes this by asserting skip_i together with opcode 0x73 on operands whose sum overflows, and together with 0x0F on an accumulator of 1. It judges the result by requiring skip_o low and the accumulator and carry returned untouched, where without skip_i both cases would have produced a skip and a new value.

// File: rtl/nibble_alu_pkg.sv
package nibble_alu_pkg;
  localparam int unsigned OPW = 8;

  typedef enum logic [2:0] {
    K_ADDI,
    K_CMPI,
    K_BITT,
    K_ADCS,
    K_ADC,
    K_TSTC,
    K_PASS,
    K_ILL
  } op_kind_e;
endpackage

// File: rtl/nalu_decode.sv
module nalu_decode
  import nibble_alu_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  output op_kind_e       kind_o
);
  always_comb begin
    unique casez (op_i)
      8'b0000_????: kind_o = K_ADDI;
      8'b0001_????: kind_o = K_CMPI;
      8'b0110_01??: kind_o = K_BITT;
      8'h73:        kind_o = K_ADCS;
      8'h72:        kind_o = K_ADC;
      8'h54:        kind_o = K_TSTC;
      8'h4e, 8'h4f: kind_o = K_ILL;
      8'b0101_10??: kind_o = K_ILL;
      default:      kind_o = K_PASS;
    endcase
  end
endmodule

// File: rtl/nalu_adder.sv
module nalu_adder #(
  parameter int unsigned DW = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o
);
  logic [DW:0] full;
  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
  assign sum_o  = full[DW-1:0];
  assign cout_o = full[DW];
endmodule

// File: rtl/nalu_test.sv
module nalu_test
  import nibble_alu_pkg::*;
#(
  parameter int unsigned DW = 4,
  localparam int unsigned SW = (DW > 1) ? $clog2(DW) : 1
) (
  input  op_kind_e      kind_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] imm_i,
  input  logic [SW-1:0] sel_i,
  input  logic          carry_i,
  output logic          hit_o
);
  always_comb begin
    unique case (kind_i)
      K_CMPI:  hit_o = (acc_i == imm_i);
      K_BITT:  hit_o = acc_i[sel_i];
      K_TSTC:  hit_o = carry_i;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nibble_alu_skip.sv
module nibble_alu_skip
  import nibble_alu_pkg::*;
#(
  parameter int unsigned DW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic           skip_i,
  input  logic [OPW-1:0] opcode_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  ram_i,
  input  logic           carry_i,
  output logic           valid_o,
  output logic [DW-1:0]  acc_o,
  output logic           carry_o,
  output logic           skip_o,
  output logic           illegal_o,
  output logic           pass_o
);
  localparam int unsigned SW = (DW > 1) ? $clog2(DW) : 1;

  op_kind_e      kind;
  logic          use_ram;
  logic [DW-1:0] add_b;
  logic          add_cin;
  logic [DW-1:0] sum;
  logic          cout;
  logic          hit;

  logic [DW-1:0] acc_n;
  logic          carry_n, skip_n, ill_n, pass_n;

  nalu_decode u_dec (
    .op_i   (opcode_i),
    .kind_o (kind)
  );

  // one adder shared by immediate and register adds
  assign use_ram = (kind == K_ADC) || (kind == K_ADCS);
  assign add_b   = use_ram ? ram_i : opcode_i[DW-1:0];
  assign add_cin = use_ram & carry_i;

  nalu_adder #(.DW(DW)) u_add (
    .a_i    (acc_i),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  nalu_test #(.DW(DW)) u_tst (
    .kind_i  (kind),
    .acc_i   (acc_i),
    .imm_i   (opcode_i[DW-1:0]),
    .sel_i   (opcode_i[SW-1:0]),
    .carry_i (carry_i),
    .hit_o   (hit)
  );

  always_comb begin
    acc_n   = acc_i;
    carry_n = carry_i;
    skip_n  = 1'b0;
    ill_n   = 1'b0;
    pass_n  = 1'b0;
    if (!skip_i) begin
      unique case (kind)
        K_ADDI: begin
          acc_n  = sum;
          skip_n = cout;
        end
        K_ADCS: begin
          acc_n   = sum;
          carry_n = cout;
          skip_n  = cout;
        end
        K_ADC: begin
          acc_n   = sum;
          carry_n = cout;
        end
        K_CMPI, K_BITT, K_TSTC: skip_n = hit;
        K_ILL:   ill_n  = 1'b1;
        default: pass_n = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      acc_o     <= '0;
      carry_o   <= 1'b0;
      skip_o    <= 1'b0;
      illegal_o <= 1'b0;
      pass_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        acc_o     <= acc_n;
        carry_o   <= carry_n;
        skip_o    <= skip_n;
        illegal_o <= ill_n;
        pass_o    <= pass_n;
      end
    end
  end
endmodule

// File: rtl/nalu_checker.sv
module nalu_checker
  import nibble_alu_pkg::*;
#(
  parameter int unsigned DW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic           skip_i,
  input logic [OPW-1:0] opcode_i,
  input logic [DW-1:0]  acc_i,
  input logic [DW-1:0]  ram_i,
  input logic           carry_i,
  input logic           valid_o,
  input logic [DW-1:0]  acc_o,
  input logic           carry_o,
  input logic           skip_o,
  input logic           illegal_o,
  input logic           pass_o
);
  logic live;
  assign live = valid_i && !skip_i;

  p_addi_keeps_carry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && (opcode_i[7:4] == 4'h0) |=> carry_o == $past(carry_i));

  p_adc_never_skips_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && (opcode_i == 8'h72) |=> !skip_o);

  p_adcs_skip_is_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && (opcode_i == 8'h73) |=> skip_o == carry_o);

  p_illegal_holds_state_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && ((opcode_i == 8'h4e) || (opcode_i == 8'h4f) || (opcode_i[7:2] == 6'b010110))
    |=> illegal_o && !skip_o && (acc_o == $past(acc_i)) && (carry_o == $past(carry_i)));

  p_suppress_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && skip_i |=> !skip_o && !illegal_o && !pass_o
      && (acc_o == $past(acc_i)) && (carry_o == $past(carry_i)));

  p_flags_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({skip_o, illegal_o, pass_o}));

  p_strobe_follows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_idle_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(acc_o) && $stable(skip_o));
endmodule

bind nibble_alu_skip nalu_checker #(.DW(DW)) u_chk (.*);

// File: tb/nibble_alu_skip_bench.sv
`timescale 1ns/1ps
module nibble_alu_skip_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic       skip_i = 1'b0;
  logic [7:0] opcode_i = '0;
  logic [3:0] acc_i = '0;
  logic [3:0] ram_i = '0;
  logic       carry_i = 1'b0;
  logic       valid_o;
  logic [3:0] acc_o;
  logic       carry_o, skip_o, illegal_o, pass_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  nibble_alu_skip u_nibble_alu_skip (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Present one opcode, then sample the registered result after the edge.
  task automatic run(input string tag, input logic [7:0] op, input logic [3:0] a,
                     input logic [3:0] r, input logic c, input logic sk,
                     input logic [3:0] e_acc, input logic e_c, input logic e_skip,
                     input logic e_ill, input logic e_pass);
    @(negedge clk_i);
    opcode_i = op; acc_i = a; ram_i = r; carry_i = c; skip_i = sk; valid_i = 1'b1;
    @(posedge clk_i);
    #1;
    valid_i = 1'b0; skip_i = 1'b0;
    chk({tag, " valid"}, int'(valid_o), 1);
    chk({tag, " acc"}, int'(acc_o), int'(e_acc));
    chk({tag, " carry"}, int'(carry_o), int'(e_c));
    chk({tag, " skip"}, int'(skip_o), int'(e_skip));
    chk({tag, " illegal"}, int'(illegal_o), int'(e_ill));
    chk({tag, " pass"}, int'(pass_o), int'(e_pass));
  endtask

  task automatic t_reset;
    chk("R10 reset valid", int'(valid_o), 0);
    chk("R10 reset acc", int'(acc_o), 0);
    chk("R10 reset flags", int'({carry_o, skip_o, illegal_o, pass_o}), 0);
  endtask

  task automatic t_addi;
    run("R1 no wrap", 8'h05, 4'hA, 4'h0, 1'b1, 1'b0, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R1 wrap", 8'h07, 4'hC, 4'h9, 1'b0, 1'b0, 4'h3, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R1 exact 16", 8'h0F, 4'h1, 4'h0, 1'b1, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_cmp;
    run("R2 equal", 8'h1A, 4'hA, 4'h0, 1'b0, 1'b0, 4'hA, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R2 differ", 8'h1A, 4'hB, 4'h0, 1'b1, 1'b0, 4'hB, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_bit;
    run("R3 bit2 set", 8'h66, 4'h4, 4'h0, 1'b0, 1'b0, 4'h4, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R3 bit3 clear", 8'h67, 4'h7, 4'h0, 1'b0, 1'b0, 4'h7, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R3 bit0 set", 8'h64, 4'h1, 4'h0, 1'b1, 1'b0, 4'h1, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_adcs;
    run("R4 overflow", 8'h73, 4'h9, 4'h6, 1'b1, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    run("R4 plain", 8'h73, 4'h2, 4'h3, 1'b0, 1'b0, 4'h5, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R4 carry in", 8'h73, 4'h2, 4'h3, 1'b1, 1'b0, 4'h6, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_adc;
    run("R5 overflow", 8'h72, 4'h9, 4'h6, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R5 carry clears", 8'h72, 4'h1, 4'h1, 1'b1, 1'b0, 4'h3, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_tc;
    run("R6 carry set", 8'h54, 4'h7, 4'h0, 1'b1, 1'b0, 4'h7, 1'b1, 1'b1, 1'b0, 1'b0);
    run("R6 carry clear", 8'h54, 4'h7, 4'h0, 1'b0, 1'b0, 4'h7, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_pass;
    run("R7 load group", 8'h35, 4'h2, 4'h0, 1'b1, 1'b0, 4'h2, 1'b1, 1'b0, 1'b0, 1'b1);
    run("R7 jump group", 8'h9C, 4'hE, 4'h0, 1'b0, 1'b0, 4'hE, 1'b0, 1'b0, 1'b0, 1'b1);
    run("R7 other", 8'h40, 4'h6, 4'h0, 1'b1, 1'b0, 4'h6, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_illegal;
    run("R8 4e", 8'h4E, 4'h3, 4'h0, 1'b1, 1'b0, 4'h3, 1'b1, 1'b0, 1'b1, 1'b0);
    run("R8 4f", 8'h4F, 4'h8, 4'h0, 1'b0, 1'b0, 4'h8, 1'b0, 1'b0, 1'b1, 1'b0);
    run("R8 58", 8'h58, 4'h1, 4'h0, 1'b0, 1'b0, 4'h1, 1'b0, 1'b0, 1'b1, 1'b0);
    run("R8 5b", 8'h5B, 4'hD, 4'h0, 1'b1, 1'b0, 4'hD, 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_suppress;
    run("R9 adcs swallowed", 8'h73, 4'h9, 4'h6, 1'b1, 1'b1, 4'h9, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R9 addi swallowed", 8'h0F, 4'h1, 4'h0, 1'b0, 1'b1, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R9 illegal swallowed", 8'h4E, 4'h5, 4'h0, 1'b0, 1'b1, 4'h5, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    run("R10 setup", 8'h03, 4'h4, 4'h0, 1'b0, 1'b0, 4'h7, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    opcode_i = 8'h0F; acc_i = 4'hF;
    @(posedge clk_i);
    #1;
    chk("R10 idle valid", int'(valid_o), 0);
    chk("R10 idle acc hold", int'(acc_o), 4'h7);
    chk("R10 idle skip hold", int'(skip_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_addi();
    t_cmp();
    t_bit();
    t_adcs();
    t_adc();
    t_tc();
    t_pass();
    t_illegal();
    t_suppress();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule